// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block sits on the host side of an 8-bit asynchronous NAND flash bus and runs one complete page program. The host hands over a 32-bit page address and a byte count with a start/ready handshake. The sequencer then writes the program opcode and four address bytes, and streams the data bytes from a valid/ready input. After the data it writes the confirm opcode and waits for the flash to finish. At the end it reports pass, fail or timeout with a one-cycle done pulse.

Every bus transfer goes through one shared strobe engine. The engine holds the latch-select lines and the data byte steady and drives write-enable (or read-enable for a status read) low for a programmable number of clock cycles, then high for another programmable number. Completion is detected in one of two ways, chosen per request: the synchronised ready/busy pin goes high and the status register is then read once, or the status register is polled until its ready bit is set. A programmable counter bounds the wait. When it expires, the flash gets a reset opcode and the host sees a timeout.

Top module: `nand_prog_seq`

## Requirements
- R1: A start is taken only while ready_o is 1. A request whose count is 0 or above 528 is rejected: done_o pulses with pass_o=0 and timeout_o=0, and no write-enable pulse is produced.
- R2: The first bus cycle of an accepted request latches opcode 0x80 with CLE=1 and ALE=0. Every bus byte is taken by the flash on the rising edge of nand_we_n_o.
- R3: Exactly four address cycles follow, with ALE=1 and CLE=0, carrying addr_i[7:0], addr_i[15:8], addr_i[23:16] and addr_i[31:24] in that order. CLE, ALE and the data byte do not change at the rising write-enable edge.
- R4: Exactly count_i data cycles follow, with CLE=0 and ALE=0, carrying the accepted wr_data_i bytes in arrival order. wr_ready_o is 0 outside the data phase.
- R5: Opcode 0x10 is latched (CLE=1) right after the last data byte.
- R6: nand_we_n_o stays low for exactly cfg_strobe_low_i cycles and high for at least cfg_strobe_high_i cycles between pulses; a setting of 0 counts as 1.
- R7: With cfg_poll_i=0 the sequencer waits for nand_rb_i to be high, then writes opcode 0x70 and reads the status byte exactly once.
- R8: With cfg_poll_i=1 the sequencer writes 0x70 once after the confirm and then repeats read-enable pulses until status bit 6 reads 1.
- R9: At completion done_o pulses for one cycle, and pass_o is 1 when status bit 0 is 0 and 0 when it is 1, with timeout_o=0.
- R10: If the flash is not ready within cfg_timeout_i cycles of the confirm, the sequencer writes 0xFF, pulses done_o with timeout_o=1 and pass_o=0.
- R11: Between the confirm and done_o, the only opcodes written are 0x70 and 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_strobe_low_i | input | CW | Strobe low width in cycles |
| cfg_strobe_high_i | input | CW | Strobe high width in cycles |
| cfg_timeout_i | input | TW | Busy-wait limit in cycles |
| cfg_poll_i | input | 1 | 1: poll status bit 6, 0: watch ready/busy |
| start_i | input | 1 | Request start |
| ready_o | output | 1 | Idle, start accepted |
| addr_i | input | 32 | Four address bytes, low byte sent first |
| count_i | input | CNTW | Data byte count (1..528) |
| wr_data_i | input | 8 | Data byte |
| wr_valid_i | input | 1 | Data byte valid |
| wr_ready_o | output | 1 | Data byte taken when valid |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Program passed |
| timeout_o | output | 1 | Busy wait timed out |
| nand_ce_n_o | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_n_o | output | 1 | Write enable, active low |
| nand_re_n_o | output | 1 | Read enable, active low |
| nand_io_o | output | 8 | Bus byte out |
| nand_io_oe_o | output | 1 | Bus output enable |
| nand_io_i | input | 8 | Bus byte in |
| nand_rb_i | input | 1 | Ready/busy, low while busy |

## Verification
The bench runs a modelled flash that goes busy on the confirm opcode. It covers one-byte and full 528-byte pages, both completion modes, failing status, and a flash that never finishes. A design that sent a wrong number of address or data bytes, or put them in the wrong order, would break the logged cycle sequence. A design that judged pass from the wrong bit, re-read in ready/busy mode, or failed to poll would give a wrong pass flag or a wrong count of read strobes. The bench also sends counts of 0 and 529 and strobe widths of 1 and 3 cycles, so it catches an off-by-one in the count bound or the width counters, and a missing reset opcode on timeout.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [1:0] {
    CYC_CMD,
    CYC_ADDR,
    CYC_DATA,
    CYC_READ
  } cyc_kind_e;

  localparam logic [7:0] OP_PROG    = 8'h80;
  localparam logic [7:0] OP_CONFIRM = 8'h10;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_RESET   = 8'hFF;

  localparam logic [7:0] STAT_READY_MASK = 8'h40;
  localparam logic [7:0] STAT_FAIL_MASK  = 8'h01;

  localparam int ADDR_CYCLES = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD_PROG,
    ST_ADDR,
    ST_DATA,
    ST_CMD_CONF,
    ST_WAIT_RB,
    ST_CMD_STAT,
    ST_READ_STAT,
    ST_CMD_RST,
    ST_FINISH
  } seq_state_e;

endpackage

// File: rtl/nps_bus_cycle.sv
module nps_bus_cycle
  import nps_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   cfg_low_i,
  input  logic [CW-1:0]   cfg_high_i,
  input  logic            go_i,
  input  cyc_kind_e       kind_i,
  input  logic [7:0]      byte_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [7:0]      rdata_o,
  output logic            cle_o,
  output logic            ale_o,
  output logic            we_n_o,
  output logic            re_n_o,
  output logic [7:0]      io_o,
  output logic            oe_o,
  input  logic [7:0]      io_i
);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  phase_e         ph_q;
  logic [CW-1:0]  cnt_q;
  cyc_kind_e      kind_q;
  logic [CW-1:0]  low_len;
  logic [CW-1:0]  high_len;

  assign low_len  = (cfg_low_i  == '0) ? CW'(1) : cfg_low_i;
  assign high_len = (cfg_high_i == '0) ? CW'(1) : cfg_high_i;

  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = (ph_q == PH_HIGH) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      kind_q  <= CYC_CMD;
      cle_o   <= 1'b0;
      ale_o   <= 1'b0;
      we_n_o  <= 1'b1;
      re_n_o  <= 1'b1;
      io_o    <= '0;
      oe_o    <= 1'b0;
      rdata_o <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (go_i) begin
            ph_q   <= PH_LOW;
            cnt_q  <= low_len - CW'(1);
            kind_q <= kind_i;
            cle_o  <= (kind_i == CYC_CMD);
            ale_o  <= (kind_i == CYC_ADDR);
            we_n_o <= (kind_i == CYC_READ);
            re_n_o <= (kind_i != CYC_READ);
            io_o   <= byte_i;
            oe_o   <= (kind_i != CYC_READ);
          end
        end
        PH_LOW: begin
          if (cnt_q == '0) begin
            ph_q   <= PH_HIGH;
            cnt_q  <= high_len - CW'(1);
            we_n_o <= 1'b1;
            re_n_o <= 1'b1;
            if (kind_q == CYC_READ) rdata_o <= io_i;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: begin
          if (cnt_q == '0) begin
            ph_q  <= PH_IDLE;
            cle_o <= 1'b0;
            ale_o <= 1'b0;
            oe_o  <= 1'b0;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
      endcase
    end
  end

  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cle_o && ale_o)); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!we_n_o && !re_n_o)); // R6

  AST_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n_o) |-> ($stable(cle_o) && $stable(ale_o) && $stable(io_o))); // R3

  AST_IO_STABLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !we_n_o |=> (we_n_o || $stable(io_o))); // R4

endmodule

// File: rtl/nps_busy_watch.sv
module nps_busy_watch #(
  parameter int TW    = 16,
  parameter int GUARD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic [TW-1:0] limit_i,
  input  logic          rb_i,
  output logic          rb_ready_o,
  output logic          expired_o
);

  localparam int GW = $clog2(GUARD + 1);

  logic          rb_s1_q;
  logic          rb_s2_q;
  logic [TW-1:0] cnt_q;
  logic [GW-1:0] guard_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_s1_q <= 1'b0;
      rb_s2_q <= 1'b0;
      cnt_q   <= '0;
      guard_q <= '0;
    end else begin
      rb_s1_q <= rb_i;
      rb_s2_q <= rb_s1_q;
      if (clear_i) begin
        cnt_q   <= '0;
        guard_q <= '0;
      end else begin
        if (cnt_q != '1) cnt_q <= cnt_q + TW'(1);
        if (guard_q != GW'(GUARD)) guard_q <= guard_q + GW'(1);
      end
    end
  end

  assign expired_o  = (cnt_q >= limit_i);
  assign rb_ready_o = rb_s2_q && (guard_q == GW'(GUARD));

  AST_EXPIRE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (expired_o && !clear_i && $stable(limit_i)) |=> expired_o); // R10

endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nps_pkg::*;
#(
  parameter int CW        = 4,
  parameter int TW        = 16,
  parameter int MAX_BYTES = 528,
  parameter int RB_GUARD  = 4,
  localparam int CNTW     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    cfg_strobe_low_i,
  input  logic [CW-1:0]    cfg_strobe_high_i,
  input  logic [TW-1:0]    cfg_timeout_i,
  input  logic             cfg_poll_i,
  input  logic             start_i,
  output logic             ready_o,
  input  logic [31:0]      addr_i,
  input  logic [CNTW-1:0]  count_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             timeout_o,
  output logic             nand_ce_n_o,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_n_o,
  output logic             nand_re_n_o,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe_o,
  input  logic [7:0]       nand_io_i,
  input  logic             nand_rb_i
);

  localparam int ACW = $clog2(ADDR_CYCLES);

  seq_state_e      st_q;
  logic [31:0]     addr_q;
  logic [ACW-1:0]  acnt_q;
  logic [CNTW-1:0] rem_q;
  logic            poll_q;
  logic            fail_q;
  logic            tmo_q;

  logic            bus_go;
  cyc_kind_e       bus_kind;
  logic [7:0]      bus_byte;
  logic            bus_busy;
  logic            bus_done;
  logic [7:0]      bus_rdata;
  logic            watch_clear;
  logic            rb_ready;
  logic            expired;
  logic            stat_ready;
  logic            stat_fail;
  logic            req_bad;

  assign ready_o    = (st_q == ST_IDLE);
  assign wr_ready_o = (st_q == ST_DATA) && !bus_busy && (rem_q != '0);
  assign stat_ready = (bus_rdata & STAT_READY_MASK) != 8'h00;
  assign stat_fail  = (bus_rdata & STAT_FAIL_MASK) != 8'h00;
  assign req_bad    = (count_i == '0) || (count_i > CNTW'(MAX_BYTES));
  assign watch_clear = !((st_q == ST_WAIT_RB) || (st_q == ST_CMD_STAT) ||
                         (st_q == ST_READ_STAT));

  always_comb begin
    bus_go   = 1'b0;
    bus_kind = CYC_CMD;
    bus_byte = OP_PROG;
    case (st_q)
      ST_CMD_PROG: begin
        bus_go   = !bus_busy;
        bus_byte = OP_PROG;
      end
      ST_ADDR: begin
        bus_go   = !bus_busy;
        bus_kind = CYC_ADDR;
        bus_byte = addr_q[7:0];
      end
      ST_DATA: begin
        bus_go   = wr_valid_i && wr_ready_o;
        bus_kind = CYC_DATA;
        bus_byte = wr_data_i;
      end
      ST_CMD_CONF: begin
        bus_go   = !bus_busy;
        bus_byte = OP_CONFIRM;
      end
      ST_CMD_STAT: begin
        bus_go   = !bus_busy;
        bus_byte = OP_STATUS;
      end
      ST_READ_STAT: begin
        bus_go   = !bus_busy;
        bus_kind = CYC_READ;
        bus_byte = 8'h00;
      end
      ST_CMD_RST: begin
        bus_go   = !bus_busy;
        bus_byte = OP_RESET;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      addr_q      <= '0;
      acnt_q      <= '0;
      rem_q       <= '0;
      poll_q      <= 1'b0;
      fail_q      <= 1'b0;
      tmo_q       <= 1'b0;
      done_o      <= 1'b0;
      pass_o      <= 1'b0;
      timeout_o   <= 1'b0;
      nand_ce_n_o <= 1'b1;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            pass_o    <= 1'b0;
            timeout_o <= 1'b0;
            tmo_q     <= 1'b0;
            if (req_bad) begin
              fail_q <= 1'b1;
              st_q   <= ST_FINISH;
            end else begin
              addr_q      <= addr_i;
              acnt_q      <= '0;
              rem_q       <= count_i;
              poll_q      <= cfg_poll_i;
              fail_q      <= 1'b0;
              nand_ce_n_o <= 1'b0;
              st_q        <= ST_CMD_PROG;
            end
          end
        end
        ST_CMD_PROG: if (bus_done) st_q <= ST_ADDR;
        ST_ADDR: begin
          if (bus_done) begin
            addr_q <= addr_q >> 8;
            acnt_q <= acnt_q + ACW'(1);
            if (acnt_q == ACW'(ADDR_CYCLES - 1)) st_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (bus_go) rem_q <= rem_q - CNTW'(1);
          if (bus_done && (rem_q == '0)) st_q <= ST_CMD_CONF;
        end
        ST_CMD_CONF: begin
          if (bus_done) st_q <= poll_q ? ST_CMD_STAT : ST_WAIT_RB;
        end
        ST_WAIT_RB: begin
          if (rb_ready)     st_q <= ST_CMD_STAT;
          else if (expired) st_q <= ST_CMD_RST;
        end
        ST_CMD_STAT: if (bus_done) st_q <= ST_READ_STAT;
        ST_READ_STAT: begin
          if (bus_done) begin
            if (stat_ready) begin
              fail_q <= stat_fail;
              st_q   <= ST_FINISH;
            end else if (expired) begin
              st_q <= ST_CMD_RST;
            end
          end
        end
        ST_CMD_RST: begin
          if (bus_done) begin
            fail_q <= 1'b1;
            tmo_q  <= 1'b1;
            st_q   <= ST_FINISH;
          end
        end
        default: begin
          done_o      <= 1'b1;
          pass_o      <= !fail_q;
          timeout_o   <= tmo_q;
          nand_ce_n_o <= 1'b1;
          st_q        <= ST_IDLE;
        end
      endcase
    end
  end

  nps_bus_cycle #(.CW(CW)) i_bus (
    .clk       (clk),
    .rst       (rst),
    .cfg_low_i (cfg_strobe_low_i),
    .cfg_high_i(cfg_strobe_high_i),
    .go_i      (bus_go),
    .kind_i    (bus_kind),
    .byte_i    (bus_byte),
    .busy_o    (bus_busy),
    .done_o    (bus_done),
    .rdata_o   (bus_rdata),
    .cle_o     (nand_cle_o),
    .ale_o     (nand_ale_o),
    .we_n_o    (nand_we_n_o),
    .re_n_o    (nand_re_n_o),
    .io_o      (nand_io_o),
    .oe_o      (nand_io_oe_o),
    .io_i      (nand_io_i)
  );

  nps_busy_watch #(.TW(TW), .GUARD(RB_GUARD)) i_watch (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (watch_clear),
    .limit_i   (cfg_timeout_i),
    .rb_i      (nand_rb_i),
    .rb_ready_o(rb_ready),
    .expired_o (expired)
  );

  logic aconf_q;
  always_ff @(posedge clk) begin
    if (rst) aconf_q <= 1'b0;
    else if (done_o) aconf_q <= 1'b0;
    else if ($rose(nand_we_n_o) && nand_cle_o && (nand_io_o == OP_CONFIRM)) aconf_q <= 1'b1;
  end

  AST_BUSY_OPCODES: assert property (@(posedge clk) disable iff (rst)
    ($fell(nand_we_n_o) && nand_cle_o && aconf_q) |->
      ((nand_io_o == OP_STATUS) || (nand_io_o == OP_RESET))); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9

  AST_PASS_TMO_EXCL: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !(pass_o && timeout_o)); // R10

  AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    rem_q <= CNTW'(MAX_BYTES)); // R4

  AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ready_o && $past(ready_o)) |-> nand_we_n_o); // R1

endmodule

// File: tb/test_nand_prog_seq.sv
`timescale 1ns/1ps
module test_nand_prog_seq;

  localparam int CW = 4;
  localparam int TW = 16;
  localparam int NB = 528;
  localparam int NW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [CW-1:0] cfg_lo = 4'd1, cfg_hi = 4'd1;
  logic [TW-1:0] cfg_tmo = 16'd4000;
  logic          cfg_poll = 1'b0;
  logic          start_i = 1'b0;
  logic [31:0]   addr_i = '0;
  logic [NW-1:0] count_i = '0;
  logic [7:0]    wr_data = '0;
  logic          wr_valid = 1'b0;
  logic ready_o, wr_ready_o, done_o, pass_o, timeout_o;
  logic nand_ce_n_o, nand_cle_o, nand_ale_o, nand_we_n_o, nand_re_n_o, nand_io_oe_o;
  logic [7:0] nand_io_o;
  wire  [7:0] nand_io_i;
  wire        nand_rb_i;

  nand_prog_seq #(.CW(CW), .TW(TW), .MAX_BYTES(NB)) i_nand_prog_seq (
    .clk(clk), .rst(rst),
    .cfg_strobe_low_i(cfg_lo), .cfg_strobe_high_i(cfg_hi),
    .cfg_timeout_i(cfg_tmo), .cfg_poll_i(cfg_poll),
    .start_i(start_i), .ready_o(ready_o), .addr_i(addr_i), .count_i(count_i),
    .wr_data_i(wr_data), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready_o),
    .done_o(done_o), .pass_o(pass_o), .timeout_o(timeout_o),
    .nand_ce_n_o(nand_ce_n_o), .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o),
    .nand_we_n_o(nand_we_n_o), .nand_re_n_o(nand_re_n_o), .nand_io_o(nand_io_o),
    .nand_io_oe_o(nand_io_oe_o), .nand_io_i(nand_io_i), .nand_rb_i(nand_rb_i)
  );

  // flash model
  int   cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  bit   log_en = 0;
  bit   cur_hang = 0;
  int   cur_busy = 0;
  bit   fail_flag = 0;
  bit   dev_hang = 0;
  int   busy_until = 0;
  logic [1:0] lk [0:2047];
  logic [7:0] lb [0:2047];
  int   nlog = 0;
  int   nread = 0;
  int   lo_bad = 0;
  int   hi_bad = 0;
  realtime t_fall = 0.0, t_rise = 0.0;
  bit   seen_rise = 0;

  wire dev_busy = dev_hang || (cyc < busy_until);
  assign nand_rb_i = !dev_busy;
  assign nand_io_i = {1'b1, !dev_busy, 5'b00000, fail_flag};

  always @(posedge nand_we_n_o) begin
    if (log_en) begin
      if (nlog < 2048) begin
        lk[nlog] = {nand_cle_o, nand_ale_o};
        lb[nlog] = nand_io_o;
      end
      nlog = nlog + 1;
      if (nand_cle_o && nand_io_o == 8'h10) begin
        if (cur_hang) dev_hang = 1;
        else busy_until = cyc + cur_busy;
      end
      if (nand_cle_o && nand_io_o == 8'hFF) dev_hang = 0;
      if ((($realtime - t_fall) < cfg_lo * 5.0 - 0.5) ||
          (($realtime - t_fall) > cfg_lo * 5.0 + 0.5)) lo_bad = lo_bad + 1;
      t_rise = $realtime;
      seen_rise = 1;
    end
  end

  always @(negedge nand_we_n_o) begin
    if (log_en) begin
      if (seen_rise && (($realtime - t_rise) < cfg_hi * 5.0 - 0.5)) hi_bad = hi_bad + 1;
      t_fall = $realtime;
    end
  end

  always @(negedge nand_re_n_o) if (log_en) nread = nread + 1;

  int ntest = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int run, input int k);
    return 8'((run * 37 + k * 13 + 5) & 255);
  endfunction

  typedef struct packed {
    logic [9:0]  cnt;
    logic        poll;
    logic        fail;
    logic        hang;
    logic [15:0] busy;
    logic [3:0]  lo;
    logic [3:0]  hi;
    logic [31:0] addr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{10'd1,   1'b0, 1'b0, 1'b0, 16'd40,  4'd1, 4'd1, 32'h0A0B0C0D},
    '{10'd528, 1'b1, 1'b0, 1'b0, 16'd200, 4'd1, 4'd2, 32'h11223344},
    '{10'd17,  1'b0, 1'b1, 1'b0, 16'd100, 4'd3, 4'd2, 32'hDEADBEEF},
    '{10'd264, 1'b1, 1'b1, 1'b0, 16'd60,  4'd2, 4'd1, 32'h00FF00FF},
    '{10'd5,   1'b0, 1'b0, 1'b1, 16'd0,   4'd1, 4'd1, 32'h80706050},
    '{10'd3,   1'b1, 1'b0, 1'b1, 16'd0,   4'd2, 4'd3, 32'h01020304}
  };

  bit dog_fired = 0;

  task automatic wait_done(output bit got, output logic p, output logic t,
                           input int run, input int cnt);
    int sent = 0;
    bit hs = 0;
    int w = 0;
    got = 0; p = 0; t = 0;
    while (!got && w < 60000) begin
      if (hs) sent++;
      wr_valid = (sent < cnt) && (w % 4 != 3);
      wr_data  = pat(run, sent);
      hs = wr_valid && wr_ready_o;
      @(negedge clk);
      w++;
      if (done_o) begin
        got = 1; p = pass_o; t = timeout_o;
      end
    end
    wr_valid = 0;
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    int base, rbase, lb0, hb0, exp_len, nd, cmd_bad;
    bit got, ok;
    logic p, t;
    v = VECS[idx];
    cfg_lo = v.lo; cfg_hi = v.hi; cfg_poll = v.poll;
    cfg_tmo = v.hang ? 16'd300 : 16'd4000;
    fail_flag = v.fail; cur_hang = v.hang; cur_busy = int'(v.busy);
    base = nlog; rbase = nread; lb0 = lo_bad; hb0 = hi_bad;
    @(negedge clk);
    addr_i = v.addr; count_i = v.cnt; start_i = 1;
    @(negedge clk);
    start_i = 0;
    wait_done(got, p, t, idx, int'(v.cnt));
    if (!got) begin
      dog_fired = 1;
      chk(0, "R9", "watchdog done", 0, 1);
      return;
    end
    nd = nlog - base;
    exp_len = int'(v.cnt) + 7 + ((v.hang && v.poll) ? 1 : 0);
    chk(nd == exp_len, "R4", "bus cycle total", nd, exp_len);
    chk(lk[base] == 2'b10 && lb[base] == 8'h80, "R2", "program opcode",
        {lk[base], lb[base]}, {2'b10, 8'h80});
    ok = 1;
    for (int i = 0; i < 4; i++)
      if (lk[base+1+i] != 2'b01 || lb[base+1+i] != v.addr[8*i +: 8]) ok = 0;
    chk(ok, "R3", "address cycles", lb[base+1], v.addr[7:0]);
    ok = 1;
    for (int k = 0; k < int'(v.cnt); k++)
      if (lk[base+5+k] != 2'b00 || lb[base+5+k] != pat(idx, k)) ok = 0;
    chk(ok, "R4", "data bytes", lb[base+5], pat(idx, 0));
    chk(lk[base+5+v.cnt] == 2'b10 && lb[base+5+v.cnt] == 8'h10, "R5", "confirm opcode",
        lb[base+5+v.cnt], 8'h10);
    cmd_bad = 0;
    for (int i = base + 6 + int'(v.cnt); i < nlog; i++)
      if (lk[i] != 2'b10 || (lb[i] != 8'h70 && lb[i] != 8'hFF)) cmd_bad++;
    chk(cmd_bad == 0, "R11", "opcodes while busy", cmd_bad, 0);
    chk(lo_bad == lb0, "R6", "strobe low width", lo_bad - lb0, 0);
    chk(hi_bad == hb0, "R6", "strobe high width", hi_bad - hb0, 0);
    if (v.hang) begin
      chk(lb[nlog-1] == 8'hFF, "R10", "reset opcode", lb[nlog-1], 8'hFF);
      chk(t == 1 && p == 0, "R10", "timeout flags", {p, t}, 2'b01);
    end else begin
      chk(lb[nlog-1] == 8'h70, "R7", "status opcode", lb[nlog-1], 8'h70);
      if (v.poll) chk(nread - rbase >= 2, "R8", "poll read count", nread - rbase, 2);
      else        chk(nread - rbase == 1, "R7", "single status read", nread - rbase, 1);
      chk(p == !v.fail && t == 0, "R9", "pass flag", {p, t}, {!v.fail, 1'b0});
    end
    chk(wr_ready_o == 0 && ready_o == 1, "R4", "ready after done",
        {wr_ready_o, ready_o}, 2'b01);
  endtask

  task automatic run_reject(input logic [NW-1:0] c);
    int base;
    bit got;
    logic p, t;
    base = nlog;
    @(negedge clk);
    count_i = c; addr_i = 32'h55AA55AA; start_i = 1;
    @(negedge clk);
    start_i = 0;
    wait_done(got, p, t, 0, 0);
    chk(got && p == 0 && t == 0, "R1", "reject flags", {got, p, t}, 3'b100);
    chk(nlog == base, "R1", "reject bus cycles", nlog - base, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ready_o == 1, "R1", "reset ready", ready_o, 1);
    chk(nand_we_n_o == 1 && nand_re_n_o == 1 && nand_ce_n_o == 1, "R6", "reset strobes",
        {nand_we_n_o, nand_re_n_o, nand_ce_n_o}, 3'b111);
    chk(done_o == 0 && wr_ready_o == 0 && nand_cle_o == 0 && nand_ale_o == 0, "R4",
        "reset handshake", {done_o, wr_ready_o, nand_cle_o, nand_ale_o}, 4'b0000);
    log_en = 1;
    for (int i = 0; i < NV; i++) begin
      if (!dog_fired) run_vec(i);
    end
    if (!dog_fired) run_reject(10'd0);
    if (!dog_fired) run_reject(10'd529);
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    #900000;
    ntest++;
    nfail++;
    $display("FAIL R9 global watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

endmodule